// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page number by reading a two-level radix page table held in memory. The address splits into two 10-bit table indices and a 12-bit page offset. Each table has 1024 entries of 4 bytes. A root pointer input gives the physical page that holds the top-level table. The walker reads the top-level entry first. If that entry is valid, its upper bits locate the second-level table, and the walker reads the selected entry there. The walk ends with a physical page number, or with a fault when either entry is marked absent.

The walker uses a memory read port that allows only one read at a time and has variable latency. Every response carries the virtual page number next to the result, so a translation cache can be filled directly. An enable input lets system software switch hardware walking off. While it is off, every accepted request is answered with a fault at once and no memory is read.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_rd_valid` and `rsp_valid` are 0.
- R2: A request accepted with `walk_en`=1 issues its first read in the next cycle, at address {root_ppn, vaddr[31:22], 2'b00}.
- R3: A read request keeps `mem_rd_valid` high with a stable address until `mem_rd_ready` is seen. No new read is issued until the response to the previous read has arrived.
- R4: A first-level entry with bit 0 (valid) equal to 0 ends the walk with a fault response, and no second read is made.
- R5: The second read address is {entry1[31:12], vaddr[21:12], 2'b00}, where entry1 is the valid first-level entry.
- R6: A second-level entry with bit 0 = 1 gives `rsp_fault`=0 and `rsp_ppn` = entry[31:12]. With bit 0 = 0 it gives `rsp_fault`=1.
- R7: Every response carries `rsp_vpn` = vaddr[31:12] of the request that started it.
- R8: A request accepted with `walk_en`=0 gives a fault response in the cycle after acceptance and makes no memory read.
- R9: `rsp_valid` is a one-cycle pulse, driven the cycle after the last memory response. `req_ready` is high only while idle, and requests presented while busy are ignored.
- R10: `root_ppn` and `walk_en` are sampled when a request is accepted. Changes to them during a walk have no effect on that walk.
- R11: A fault response reports `rsp_ppn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_en | input | 1 | Hardware walking enabled |
| root_ppn | input | 20 | Physical page of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry read |
| rsp_valid | output | 1 | Walk result, one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_vpn | output | 20 | Virtual page number of the walk |
| rsp_ppn | output | 20 | Translated physical page number, 0 on fault |

## Verification
A wrong walk state appears at the ports within one cycle. It shows as a read request that is missing or present when it should not be, a read to the wrong address, `req_ready` high while a walk is in flight, or a response pulse in the wrong cycle. A corrupted latched value is caught at the next read address or at the response: the bench compares the read address on every cycle the request is valid, and the response fields in the exact cycle after the last memory reply. Memory latency and acceptance stall vary from walk to walk. Junk requests, root values and enable changes are presented while the walker is busy, so sampling errors reach the ports.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W_DEF      = 32;
    localparam int PA_W_DEF      = 32;
    localparam int OFF_W_DEF     = 12;
    localparam int IDX_W_DEF     = 10;
    localparam int PTE_SHIFT_DEF = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ_L1 = 3'd1,
        ST_WAIT_L1 = 3'd2,
        ST_READ_L2 = 3'd3,
        ST_WAIT_L2 = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W      = ptw_pkg::PA_W_DEF,
    parameter int OFF_W     = ptw_pkg::OFF_W_DEF,
    parameter int IDX_W     = ptw_pkg::IDX_W_DEF,
    parameter int PTE_SHIFT = ptw_pkg::PTE_SHIFT_DEF,
    localparam int PPN_W    = PA_W - OFF_W
) (
    input  logic [PPN_W-1:0] table_ppn,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    logic [PA_W-1:0] base_addr;
    logic [PA_W-1:0] slot_offs;

    // Table is page aligned; slot index scaled by entry size.
    assign base_addr  = {table_ppn, {OFF_W{1'b0}}};
    assign slot_offs  = PA_W'(index) << PTE_SHIFT;
    assign entry_addr = base_addr | slot_offs;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PA_W   = ptw_pkg::PA_W_DEF,
    parameter int OFF_W  = ptw_pkg::OFF_W_DEF,
    localparam int PPN_W = PA_W - OFF_W
) (
    input  logic [PA_W-1:0]  pte,
    output logic             pte_valid,
    output logic [PPN_W-1:0] pte_ppn
);
    assign pte_valid = pte[0];
    assign pte_ppn   = pte[PA_W-1:OFF_W];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = VA_W_DEF,
    parameter int PA_W      = PA_W_DEF,
    parameter int OFF_W     = OFF_W_DEF,
    parameter int IDX_W     = IDX_W_DEF,
    parameter int PTE_SHIFT = PTE_SHIFT_DEF,
    localparam int PPN_W    = PA_W - OFF_W,
    localparam int VPN_W    = VA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             walk_en,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [VPN_W-1:0] rsp_vpn,
    output logic [PPN_W-1:0] rsp_ppn
);
    localparam int LEVELS = 2;

    typedef struct packed {
        walk_state_e      state;
        logic [VA_W-1:0]  vaddr;
        logic [PPN_W-1:0] root;
        logic [PPN_W-1:0] l2_base;
        logic [PPN_W-1:0] ppn;
        logic             fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic             pte_valid;
    logic [PPN_W-1:0] pte_ppn;
    logic [PPN_W-1:0] lvl_table [LEVELS];
    logic [PA_W-1:0]  lvl_addr  [LEVELS];

    // One address generator per tree level; level 0 uses the high index.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (g == 0) begin : g_root
            assign lvl_table[g] = r_q.root;
        end else begin : g_leaf
            assign lvl_table[g] = r_q.l2_base;
        end
        ptw_addr_gen #(
            .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_SHIFT(PTE_SHIFT)
        ) u_agen (
            .table_ppn (lvl_table[g]),
            .index     (r_q.vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W]),
            .entry_addr(lvl_addr[g])
        );
    end

    ptw_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
        .pte      (mem_rsp_data),
        .pte_valid(pte_valid),
        .pte_ppn  (pte_ppn)
    );

    always_comb begin
        r_d          = r_q;
        mem_rd_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.root  = root_ppn;
                    r_d.ppn   = '0;
                    r_d.fault = !walk_en;
                    r_d.state = walk_en ? ST_READ_L1 : ST_DONE;
                end
            end
            ST_READ_L1: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_ready) r_d.state = ST_WAIT_L1;
            end
            ST_WAIT_L1: begin
                if (mem_rsp_valid) begin
                    if (pte_valid) begin
                        r_d.l2_base = pte_ppn;
                        r_d.state   = ST_READ_L2;
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_READ_L2: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_ready) r_d.state = ST_WAIT_L2;
            end
            ST_WAIT_L2: begin
                if (mem_rsp_valid) begin
                    r_d.fault = !pte_valid;
                    r_d.ppn   = pte_valid ? pte_ppn : '0;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign mem_rd_addr = (r_q.state == ST_READ_L2) ? lvl_addr[1] : lvl_addr[0];
    assign rsp_valid   = (r_q.state == ST_DONE);
    assign rsp_fault   = r_q.fault;
    assign rsp_vpn     = r_q.vaddr[VA_W-1:OFF_W];
    assign rsp_ppn     = r_q.ppn;

    // R2: first read follows acceptance with the sampled root and top index
    p_l1_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && walk_en) |=> mem_rd_valid &&
        mem_rd_addr == ({$past(root_ppn), {OFF_W{1'b0}}} |
                        (PA_W'($past(req_vaddr[VA_W-1 -: IDX_W])) << PTE_SHIFT)));

    // R3: a stalled read holds its address
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

    // R3: single outstanding read
    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    // R4: absent first-level entry ends the walk with a fault
    p_l1_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT_L1 && mem_rsp_valid && !mem_rsp_data[0])
        |=> rsp_valid && rsp_fault && !mem_rd_valid);

    // R6: valid leaf entry yields its page number
    p_leaf_ppn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT_L2 && mem_rsp_valid && mem_rsp_data[0])
        |=> rsp_valid && !rsp_fault && rsp_ppn == $past(mem_rsp_data[PA_W-1:OFF_W]));

    // R8: disabled walker faults at once
    p_disabled_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !walk_en) |=> rsp_valid && rsp_fault && !mem_rd_valid);

    // R9: response is a single-cycle pulse
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: faults carry a zero page number
    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_ppn == '0);
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        walk_en;
    logic [19:0] root_ppn;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [19:0] rsp_vpn;
    logic [19:0] rsp_ppn;

    always #10 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .walk_en(walk_en), .root_ppn(root_ppn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_vpn(rsp_vpn), .rsp_ppn(rsp_ppn)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Model state
    int          ph = 0;      // 0 idle, 1 read expected, 2 awaiting memory, 3 response due
    int          nread;
    int          exp_reads;
    int          lat;
    int          walks = 0;
    int          n_ok = 0;
    int          n_f1 = 0;
    int          n_dis = 0;
    logic [31:0] exp_a [2];
    logic        exp_fault;
    logic        exp_en;
    logic [19:0] exp_ppn;
    logic [19:0] exp_vpn;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Memory contents as a pure function of the address.
    function automatic logic [31:0] memf(input logic [31:0] a);
        logic [31:0] x;
        x = a * 32'h9E37_79B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EB_CA6B;
        x = x ^ (x >> 13);
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_walk();
        logic [31:0] va;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [19:0] rt;
        va = rnd();
        rt = rnd() >> 12;
        exp_en = (walks % 6) != 5;
        req_valid = 1'b1;
        req_vaddr = va;
        root_ppn  = rt;
        walk_en   = exp_en;
        exp_vpn   = va[31:12];
        exp_ppn   = '0;
        nread     = 0;
        walks++;
        if (!exp_en) begin
            exp_reads = 0; exp_fault = 1'b1; ph = 3; n_dis++;
        end else begin
            exp_a[0] = {rt, va[31:22], 2'b00};
            e1 = memf(exp_a[0]);
            if (!e1[0]) begin
                exp_reads = 1; exp_fault = 1'b1; n_f1++;
            end else begin
                exp_a[1] = {e1[31:12], va[21:12], 2'b00};
                e2 = memf(exp_a[1]);
                exp_reads = 2;
                exp_fault = !e2[0];
                exp_ppn   = e2[0] ? e2[31:12] : 20'd0;
                if (e2[0]) n_ok++;
            end
            ph = 1;
        end
    endtask

    task automatic junk_inputs();
        logic [31:0] r;
        r = rnd();
        req_valid = r[3];
        req_vaddr = rnd();
        root_ppn  = r[31:12];
        walk_en   = r[5];
    endtask

    task automatic step();
        logic [31:0] r;
        r = rnd();
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = rnd();
        mem_rd_ready  = 1'b0;
        case (ph)
            0: begin
                chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
                chk(mem_rd_valid == 1'b0, "R3 no read when idle", 32'(mem_rd_valid), 0);
                chk(rsp_valid == 1'b0, "R9 no response when idle", 32'(rsp_valid), 0);
                if (r[1:0] != 2'b00) start_walk();
                else begin
                    req_valid = 1'b0;
                    walk_en   = r[7];
                end
            end
            1: begin
                chk(mem_rd_valid == 1'b1, "R3 read held until accepted", 32'(mem_rd_valid), 1);
                chk(mem_rd_addr == exp_a[nread], (nread == 0) ? "R2,R10 first address" : "R5,R10 second address",
                    mem_rd_addr, exp_a[nread]);
                chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
                chk(rsp_valid == 1'b0, "R9 no early response", 32'(rsp_valid), 0);
                junk_inputs();
                mem_rd_ready = r[0];
                if (r[0]) begin
                    ph  = 2;
                    lat = int'(r[9:8]);
                end
            end
            2: begin
                chk(mem_rd_valid == 1'b0, "R3 single outstanding read", 32'(mem_rd_valid), 0);
                chk(rsp_valid == 1'b0, "R9 no early response", 32'(rsp_valid), 0);
                chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
                junk_inputs();
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memf(exp_a[nread]);
                    nread++;
                    ph = (nread == exp_reads) ? 3 : 1;
                end else lat--;
            end
            default: begin
                chk(rsp_valid == 1'b1, !exp_en ? "R8 immediate response" : "R9 response timing",
                    32'(rsp_valid), 1);
                chk(rsp_fault == exp_fault,
                    !exp_en ? "R8 fault" : (exp_reads == 1 ? "R4 level-one fault" : "R6 fault flag"),
                    32'(rsp_fault), 32'(exp_fault));
                chk(rsp_ppn == exp_ppn, exp_fault ? "R11 fault ppn" : "R6 ppn",
                    32'(rsp_ppn), 32'(exp_ppn));
                chk(rsp_vpn == exp_vpn, "R7 vpn", 32'(rsp_vpn), 32'(exp_vpn));
                chk(mem_rd_valid == 1'b0, exp_reads == 1 ? "R4 no second read" : "R8 no read",
                    32'(mem_rd_valid), 0);
                chk(req_ready == 1'b0, "R9 not ready in response cycle", 32'(req_ready), 0);
                junk_inputs();
                ph = 0;
            end
        endcase
    endtask

    initial begin
        rst_n = 1'b0;
        walk_en = 1'b1; root_ppn = '0; req_valid = 1'b0; req_vaddr = '0;
        mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(mem_rd_valid == 1'b0, "R1 no read after reset", 32'(mem_rd_valid), 0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        while (walks < 120 || ph != 0) begin
            @(negedge clk);
            step();
        end
        chk(n_ok > 0 && n_f1 > 0 && n_dis > 0, "R4,R6,R8 coverage of outcomes",
            32'(n_ok), 1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule